// File: doc/BRIEF.md
# Return-address ring with single-interrupt control

This block keeps the return addresses of a small 8-bit processor core. The core reports each completed instruction with a one-cycle `step` strobe. With that strobe it sends a command code, the address of the instruction that would run next, and its current carry and zero flags. A call stores that address. A return or an interrupt return takes the most recent address back out and hands it to the core as a program-counter redirect. A taken interrupt stores the next address and redirects to address 0. It also saves both flags in shadow registers and raises an acknowledge that stays high until the interrupt return.

The storage is a ring of `DEPTH` entries, where `DEPTH` is a power of two. The pointer simply wraps. Pushing more than `DEPTH` addresses overwrites the oldest entries, and popping past empty reads whatever the slot holds. Nothing reports either case. All outputs are registered and appear in the cycle after the `step` that caused them.

Top module: `callstack_irq`

## Requirements
- R1: After reset, `irq_ack`, `tgt_valid` and `rest_valid` are 0 and interrupts are masked. A `step` with `irq` high and no unmask command before it redirects nothing and leaves `irq_ack` at 0.
- R2: Command codes on `cmd` are 0 none, 1 call, 2 return, 3 interrupt return, 4 unmask, 5 mask, and 6 and 7 act as none. A call stores `next_pc`. A return makes `tgt_valid` high for one cycle with `tgt_pc` equal to the most recently stored address not yet taken back, in last-in first-out order.
- R3: The ring holds `DEPTH` entries and its pointer wraps modulo `DEPTH`. After DEPTH+1 calls with values v0..vDEPTH, successive returns give vDEPTH, vDEPTH-1, ..., v1, and then vDEPTH again.
- R4: An interrupt is taken on a `step` with `irq` high while interrupts are unmasked and no handler is active. In the next cycle `tgt_valid` is 1, `tgt_pc` is 0 and `irq_ack` is 1, and `next_pc` has been stored as a return address.
- R5: On interrupt entry `flag_c` and `flag_z` are saved. An interrupt return sets `rest_valid` for one cycle and presents the saved values on `rest_c` and `rest_z`.
- R6: `irq_ack` stays high from interrupt entry until an interrupt return. The interrupt return clears it and redirects to the popped address.
- R7: While a handler is active, `irq` has no effect. No redirect happens except for returns.
- R8: Command 4 unmasks and command 5 masks the interrupt. A high `irq` without `step` is never taken.
- R9: If an interrupt is taken on a `step`, the command of that step has no effect. Only one address, `next_pc`, is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Instruction boundary strobe; qualifies cmd and irq |
| cmd | input | 3 | Command code (see R2) |
| next_pc | input | PCW | Address of the instruction that would run next |
| flag_c | input | 1 | Current carry flag |
| flag_z | input | 1 | Current zero flag |
| irq | input | 1 | Level-sensitive interrupt request |
| tgt_pc | output | PCW | Redirect address |
| tgt_valid | output | 1 | tgt_pc is to be loaded this cycle |
| rest_c | output | 1 | Restored carry flag |
| rest_z | output | 1 | Restored zero flag |
| rest_valid | output | 1 | rest_c and rest_z are to be loaded this cycle |
| irq_ack | output | 1 | Interrupt handler active |

## Verification
The properties take for granted that `cmd`, `irq` and `step` are known values at every edge after reset, and that `cmd` and `irq` matter only when `step` is high. They also assume that pop and push never coincide, which the controller enforces. The stimulus draws every command code 0 to 7 and a sparse `irq` from a seeded `$urandom`, including codes 6 and 7, interrupt returns with no handler active, and steps with `irq` but no `step`. Before any random return, all ring slots are filled by directed calls, so no pop reads an unwritten entry.

// File: rtl/cstk_pkg.sv
package cstk_pkg;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_CALL = 3'd1,
    CMD_RET  = 3'd2,
    CMD_RETI = 3'd3,
    CMD_SEI  = 3'd4,
    CMD_CLI  = 3'd5
  } cstk_cmd_e;
endpackage

// File: rtl/cstk_ring.sv
module cstk_ring #(
  parameter int DEPTH = 8,
  parameter int PCW   = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic           pop,
  input  logic [PCW-1:0] din,
  output logic [PCW-1:0] dout,
  output logic [AW-1:0]  sp
);
  logic [PCW-1:0] mem [DEPTH];

  // write port, no reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (push) mem[sp] <= din;
  end

  // registered read of the top entry
  always_ff @(posedge clk) begin
    if (pop) dout <= mem[sp - 1'b1];
  end

  // wrapping pointer: natural modulo of the AW-bit width
  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp + 1'b1;
    else if (pop)  sp <= sp - 1'b1;
  end
endmodule

// File: rtl/cstk_irq.sv
module cstk_irq
  import cstk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      step,
  input  cstk_cmd_e op,
  input  logic      irq,
  input  logic      flag_c,
  input  logic      flag_z,
  output logic      take,
  output logic      ien,
  output logic      active,
  output logic      sh_c,
  output logic      sh_z
);
  assign take = step & irq & ien & ~active;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien    <= 1'b0;
      active <= 1'b0;
      sh_c   <= 1'b0;
      sh_z   <= 1'b0;
    end else if (take) begin
      active <= 1'b1;
      sh_c   <= flag_c;
      sh_z   <= flag_z;
    end else if (step) begin
      case (op)
        CMD_SEI:  ien    <= 1'b1;
        CMD_CLI:  ien    <= 1'b0;
        CMD_RETI: active <= 1'b0;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/callstack_irq.sv
module callstack_irq
  import cstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PCW   = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic [2:0]     cmd,
  input  logic [PCW-1:0] next_pc,
  input  logic           flag_c,
  input  logic           flag_z,
  input  logic           irq,
  output logic [PCW-1:0] tgt_pc,
  output logic           tgt_valid,
  output logic           rest_c,
  output logic           rest_z,
  output logic           rest_valid,
  output logic           irq_ack
);
  localparam int AW = $clog2(DEPTH);

  cstk_cmd_e      op;
  logic           take, ien, active, sh_c, sh_z;
  logic           push, pop, is_reti, vec_q;
  logic [AW-1:0]  sp;
  logic [PCW-1:0] ring_q;

  assign op = cstk_cmd_e'(cmd);

  cstk_irq u_irq (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .op     (op),
    .irq    (irq),
    .flag_c (flag_c),
    .flag_z (flag_z),
    .take   (take),
    .ien    (ien),
    .active (active),
    .sh_c   (sh_c),
    .sh_z   (sh_z)
  );

  // an accepted interrupt overrides the step's own command
  assign push    = take | (step & (op == CMD_CALL));
  assign pop     = step & ~take & ((op == CMD_RET) | (op == CMD_RETI));
  assign is_reti = pop & (op == CMD_RETI);

  cstk_ring #(.DEPTH(DEPTH), .PCW(PCW)) u_ring (
    .clk  (clk),
    .rst  (rst),
    .push (push),
    .pop  (pop),
    .din  (next_pc),
    .dout (ring_q),
    .sp   (sp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_valid  <= 1'b0;
      vec_q      <= 1'b0;
      rest_valid <= 1'b0;
      rest_c     <= 1'b0;
      rest_z     <= 1'b0;
    end else begin
      tgt_valid  <= take | pop;
      vec_q      <= take;
      rest_valid <= is_reti;
      if (is_reti) begin
        rest_c <= sh_c;
        rest_z <= sh_z;
      end
    end
  end

  assign tgt_pc  = vec_q ? '0 : ring_q;
  assign irq_ack = active;
endmodule

// File: rtl/cstk_checker.sv
module cstk_checker #(
  parameter int PCW = 10,
  parameter int AW  = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           step,
  input logic [2:0]     cmd,
  input logic           irq,
  input logic           ien,
  input logic           push,
  input logic           pop,
  input logic [AW-1:0]  sp,
  input logic [PCW-1:0] tgt_pc,
  input logic           tgt_valid,
  input logic           rest_valid,
  input logic           irq_ack
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_ack && !tgt_valid && !rest_valid));

  // R3
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |=> (sp == $past(sp) + 1'b1));

  a_r3_pop_wrap: assert property (@(posedge clk) disable iff (rst)
    pop |=> (sp == $past(sp) - 1'b1));

  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));

  // R4
  a_r4_vector: assert property (@(posedge clk) disable iff (rst)
    (step && irq && ien && !irq_ack) |=> (tgt_valid && tgt_pc == '0 && irq_ack));

  // R5
  a_r5_flags_back: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && step && cmd == 3'd3) |=> rest_valid);

  // R6
  a_r6_ack_holds: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !(step && cmd == 3'd3)) |=> irq_ack);

  a_r6_ack_drops: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && step && cmd == 3'd3) |=> !irq_ack);

  // R7
  a_r7_no_nest: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !(step && (cmd == 3'd2 || cmd == 3'd3))) |=> !tgt_valid);

  // R8
  a_r8_boundary: assert property (@(posedge clk) disable iff (rst)
    (!step && !irq_ack) |=> !irq_ack);
endmodule

bind callstack_irq cstk_checker #(.PCW(PCW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .step       (step),
  .cmd        (cmd),
  .irq        (irq),
  .ien        (ien),
  .push       (push),
  .pop        (pop),
  .sp         (sp),
  .tgt_pc     (tgt_pc),
  .tgt_valid  (tgt_valid),
  .rest_valid (rest_valid),
  .irq_ack    (irq_ack)
);

// File: tb/callstack_irq_test.sv
module callstack_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int PCW   = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           step = 1'b0;
  logic [2:0]     cmd = 3'd0;
  logic [PCW-1:0] next_pc = '0;
  logic           flag_c = 1'b0, flag_z = 1'b0, irq = 1'b0;
  logic [PCW-1:0] tgt_pc;
  logic           tgt_valid, rest_c, rest_z, rest_valid, irq_ack;

  int total = 0;
  int bad   = 0;

  logic [PCW-1:0] mstk [DEPTH];
  int             msp = 0;
  logic           mien = 1'b0, mact = 1'b0, msc = 1'b0, msz = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  callstack_irq #(.DEPTH(DEPTH), .PCW(PCW)) uut (
    .clk(clk), .rst(rst), .step(step), .cmd(cmd), .next_pc(next_pc),
    .flag_c(flag_c), .flag_z(flag_z), .irq(irq), .tgt_pc(tgt_pc),
    .tgt_valid(tgt_valid), .rest_c(rest_c), .rest_z(rest_z),
    .rest_valid(rest_valid), .irq_ack(irq_ack)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one instruction boundary; model predicts the registered outputs
  task automatic do_step(input string tag, input logic [2:0] c, input logic rq,
                         input logic [PCW-1:0] npc, input logic fc, input logic fz);
    logic ev, erv, ec, ez;
    logic [PCW-1:0] epc;
    logic tk;
    ev = 0; erv = 0; epc = '0; ec = 0; ez = 0;
    tk = rq && mien && !mact;
    if (tk) begin
      mstk[msp] = npc; msp = (msp + 1) % DEPTH;
      ev = 1; epc = '0; mact = 1; msc = fc; msz = fz;
    end else begin
      case (c)
        3'd1: begin mstk[msp] = npc; msp = (msp + 1) % DEPTH; end
        3'd2: begin msp = (msp + DEPTH - 1) % DEPTH; epc = mstk[msp]; ev = 1; end
        3'd3: begin
          msp = (msp + DEPTH - 1) % DEPTH; epc = mstk[msp]; ev = 1;
          erv = 1; ec = msc; ez = msz; mact = 0;
        end
        3'd4: mien = 1;
        3'd5: mien = 0;
        default: ;
      endcase
    end
    @(negedge clk);
    step = 1; cmd = c; irq = rq; next_pc = npc; flag_c = fc; flag_z = fz;
    @(posedge clk); #1;
    chk(tag, "tgt_valid", 32'(tgt_valid), 32'(ev));
    if (ev) chk(tag, "tgt_pc", 32'(tgt_pc), 32'(epc));
    chk(tag, "irq_ack", 32'(irq_ack), 32'(mact));
    chk(tag, "rest_valid", 32'(rest_valid), 32'(erv));
    if (erv) chk(tag, "rest_flags", {30'd0, rest_c, rest_z}, {30'd0, ec, ez});
  endtask

  task automatic idle(input string tag, input logic rq);
    @(negedge clk);
    step = 0; cmd = 3'd0; irq = rq;
    @(posedge clk); #1;
    chk(tag, "idle tgt_valid", 32'(tgt_valid), 32'd0);
    chk(tag, "idle irq_ack", 32'(irq_ack), 32'(mact));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R1", "reset ack", 32'(irq_ack), 32'd0);
    chk("R1", "reset tgt_valid", 32'(tgt_valid), 32'd0);
    chk("R1", "reset rest_valid", 32'(rest_valid), 32'd0);
    do_step("R1", 3'd0, 1'b1, 10'h055, 1'b1, 1'b1);   // masked after reset

    // R3: DEPTH+1 calls fill every slot and overwrite the oldest
    for (int i = 0; i <= DEPTH; i++) do_step("R3", 3'd1, 1'b0, 10'(16'h100 + i), 0, 0);
    for (int i = 0; i <= DEPTH; i++) do_step("R3", 3'd2, 1'b0, '0, 0, 0);

    // R2: nested calls, LIFO
    do_step("R2", 3'd1, 0, 10'h011, 0, 0);
    do_step("R2", 3'd1, 0, 10'h022, 0, 0);
    do_step("R2", 3'd6, 0, 10'h033, 0, 0);
    do_step("R2", 3'd2, 0, '0, 0, 0);
    do_step("R2", 3'd2, 0, '0, 0, 0);

    // R8: unmask, irq without step ignored
    do_step("R8", 3'd4, 0, 10'h000, 0, 0);
    idle("R8", 1'b1);
    idle("R8", 1'b1);

    // R4/R9: interrupt with a call in the same step
    do_step("R9", 3'd1, 1'b1, 10'h2a5, 1'b1, 1'b0);
    // R7: irq held during the handler
    do_step("R7", 3'd0, 1'b1, 10'h111, 0, 1);
    do_step("R7", 3'd1, 1'b1, 10'h123, 0, 1);
    idle("R6", 1'b1);
    do_step("R7", 3'd2, 1'b1, '0, 0, 0);
    // R5/R6: return restores carry=1 zero=0, returns to 2a5
    do_step("R5", 3'd3, 1'b0, '0, 0, 1);
    idle("R6", 1'b0);
    // R8: mask then irq ignored, unmask then taken with flags 0/1
    do_step("R8", 3'd5, 0, '0, 0, 0);
    do_step("R8", 3'd0, 1'b1, 10'h077, 0, 0);
    do_step("R8", 3'd4, 0, '0, 0, 0);
    do_step("R4", 3'd7, 1'b1, 10'h3c3, 1'b0, 1'b1);
    do_step("R5", 3'd3, 1'b0, '0, 1, 1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] c;
      c = 3'($urandom % 8);
      if (($urandom % 5) == 0) idle("R8", 1'($urandom % 2));
      else do_step("R2", c, 1'(($urandom % 4) == 0), 10'($urandom),
                   1'($urandom), 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule